// File: doc/BRIEF.md
# Three-Level Interrupt Priority Encoder

This block gathers interrupt requests from three levels (critical, main and peripheral) and registers them once. It gates the main and peripheral requests with per-source disable masks and picks one winning source per level. Software reads the result as a single packed status word, while one summary line interrupts the processor. Two cascade paths link the levels. Urgent-class peripheral requests surface on the critical level as source 2. All other peripheral requests surface on the main level as source 4. When software sees either marker, it reads the peripheral field of the same word.

A small word-addressed register port holds the two mask words and five priority words. The priority words are plain read/write storage and take no part in selection. The port also reads back the packed word and three per-level status words. The urgent class of each peripheral source is fixed by a parameter.

Top module: `irq_prio_enc`

## Requirements
- R1: Synchronous reset loads peripheral mask 0x7FFFFC00 and main mask 0x00010FFF, clears all five priority words, and leaves `cpu_irq_o` low and the packed word 0.
- R2: The packed word (offset 0x24) has these fields, with all other bits 0: critical valid at bit 10 and critical source at bits 9:8; main valid at bit 21 and main source at bits 20:16; peripheral valid at bit 29 and peripheral source at bits 28:24.
- R3: Within a level, the lowest-numbered enabled pending source is reported. The source field of a level with no valid request reads 0.
- R4: An enabled peripheral request in the urgent class (default sources 1 and 2) raises critical source 2. An enabled request outside that class raises main source 4, which obeys main mask bit 11 like any main source.
- R5: The peripheral field reports the lowest urgent-class request if there is one. Otherwise it reports the lowest other request.
- R6: A mask bit at 1 disables its source. Peripheral source n is governed by bit 31-n of the word at 0x00, and main source n by bit 15-n of the word at 0x14.
- R7: The external critical input bit 2 and main input bit 4 are ignored. Only the cascade drives those positions.
- R8: `cpu_irq_o` is high exactly when at least one of the three valid bits is set, and the packed word is 0 when nothing is pending.
- R9: The priority words at 0x04, 0x08, 0x0C, 0x18 and 0x1C read back what was written. Writes to read-only offsets are ignored, and unmapped offsets (such as 0x10 and 0x38) read 0.
- R10: Requests are registered once, so `cpu_irq_o` follows an input change after one clock edge. Read data is registered and reflects the address presented one edge earlier.
- R11: The status words hold bit n = enabled pending source n of their level, cascade included: critical at 0x28, main at 0x2C, peripheral at 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crit_irq_i | input | NCRIT (4) | Critical-level requests, bit 2 unused |
| main_irq_i | input | NMAIN (16) | Main-level requests, bit 4 unused |
| per_irq_i | input | NPER (22) | Peripheral-level requests |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cpu_irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench applies request patterns with more than one source pending per level. A design that let the highest index win, or that mixed up the two peripheral classes, would report the wrong source or the wrong cascade marker. It also drives the ignored input bits on their own. A design that passed them through would raise a spurious marker with no peripheral behind it. Single-bit mask words exercise the reversed bit order. A main mask that blocks source 4 while a peripheral stays pending tests that the peripheral field stays valid even when its cascade marker is disabled. Reset values, read-back of the priority storage, and writes to read-only offsets complete the set.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 6;

  // Register word offsets
  localparam logic [ADDR_W-1:0] OFS_PER_MASK  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PER_PRI0  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_PER_PRI1  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_PER_PRI2  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_MAIN_MASK = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_MAIN_PRI0 = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MAIN_PRI1 = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_ENCODED   = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_CRIT_STAT = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_MAIN_STAT = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_PER_STAT  = 6'h30;

  // Packed status word layout
  localparam int CRIT_VLD_BIT = 10;
  localparam int CRIT_SRC_LSB = 8;
  localparam int CRIT_SRC_W   = 2;
  localparam int MAIN_VLD_BIT = 21;
  localparam int MAIN_SRC_LSB = 16;
  localparam int MAIN_SRC_W   = 5;
  localparam int PER_VLD_BIT  = 29;
  localparam int PER_SRC_LSB  = 24;
  localparam int PER_SRC_W    = 5;

  // Cascade markers
  localparam int CRIT_CASCADE = 2;
  localparam int MAIN_CASCADE = 4;

  // Reset values of the disable masks
  localparam logic [REG_W-1:0] PER_MASK_RST  = 32'h7FFF_FC00;
  localparam logic [REG_W-1:0] MAIN_MASK_RST = 32'h0001_0FFF;

  localparam int NUM_PRI = 5;

  typedef struct packed {
    logic                  valid;
    logic [PER_SRC_W-1:0]  src;
  } pick_t;
endpackage

// File: rtl/irqenc_pick.sv
module irqenc_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqenc_regs.sv
module irqenc_regs
  import irqenc_pkg::*;
#(
  parameter int NCRIT = 4,
  parameter int NMAIN = 16,
  parameter int NPER  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W-1:0]  enc_word,
  input  logic [NCRIT-1:0]  crit_stat,
  input  logic [NMAIN-1:0]  main_stat,
  input  logic [NPER-1:0]   per_stat,
  output logic [REG_W-1:0]  per_mask,
  output logic [REG_W-1:0]  main_mask,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] pri_q [NUM_PRI];
  logic [NUM_PRI-1:0] pri_hit;

  localparam logic [ADDR_W-1:0] PRI_OFS [NUM_PRI] =
    '{OFS_PER_PRI0, OFS_PER_PRI1, OFS_PER_PRI2, OFS_MAIN_PRI0, OFS_MAIN_PRI1};

  generate
    for (genvar g = 0; g < NUM_PRI; g++) begin : g_pri
      assign pri_hit[g] = (addr == PRI_OFS[g]);
      always_ff @(posedge clk) begin
        if (rst)                 pri_q[g] <= '0;
        else if (we && pri_hit[g]) pri_q[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      per_mask  <= PER_MASK_RST;
      main_mask <= MAIN_MASK_RST;
    end else if (we) begin
      if (addr == OFS_PER_MASK)  per_mask  <= wdata;
      if (addr == OFS_MAIN_MASK) main_mask <= wdata;
    end
  end

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PRI; i++) begin
      if (pri_hit[i]) rd_mux = pri_q[i];
    end
    unique case (addr)
      OFS_PER_MASK:  rd_mux = per_mask;
      OFS_MAIN_MASK: rd_mux = main_mask;
      OFS_ENCODED:   rd_mux = enc_word;
      OFS_CRIT_STAT: rd_mux = REG_W'(crit_stat);
      OFS_MAIN_STAT: rd_mux = REG_W'(main_stat);
      OFS_PER_STAT:  rd_mux = REG_W'(per_stat);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irqenc_pkg::*;
#(
  parameter int          NCRIT      = 4,
  parameter int          NMAIN      = 16,
  parameter int          NPER       = 22,
  parameter logic [31:0] URGENT_SET = 32'h0000_0006
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCRIT-1:0]  crit_irq_i,
  input  logic [NMAIN-1:0]  main_irq_i,
  input  logic [NPER-1:0]   per_irq_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              cpu_irq_o
);
  localparam logic [NPER-1:0] URGENT = URGENT_SET[NPER-1:0];

  // Input capture
  logic [NCRIT-1:0] crit_q;
  logic [NMAIN-1:0] main_q;
  logic [NPER-1:0]  per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crit_q <= '0;
      main_q <= '0;
      per_q  <= '0;
    end else begin
      crit_q <= crit_irq_i;
      main_q <= main_irq_i;
      per_q  <= per_irq_i;
    end
  end

  logic [REG_W-1:0] per_mask, main_mask, enc_word;

  // Peripheral level: reversed-order disable mask
  logic [NPER-1:0] per_en;
  generate
    for (genvar n = 0; n < NPER; n++) begin : g_per_gate
      assign per_en[n] = per_q[n] & ~per_mask[REG_W-1-n];
    end
  endgenerate

  logic [NPER-1:0] urg_req, norm_req;
  assign urg_req  = per_en & URGENT;
  assign norm_req = per_en & ~URGENT;

  logic                 urg_vld, norm_vld;
  logic [PER_SRC_W-1:0] urg_idx, norm_idx;

  irqenc_pick #(.N(NPER), .IW(PER_SRC_W)) u_pick_urg (
    .req(urg_req), .valid(urg_vld), .idx(urg_idx));
  irqenc_pick #(.N(NPER), .IW(PER_SRC_W)) u_pick_norm (
    .req(norm_req), .valid(norm_vld), .idx(norm_idx));

  pick_t per_pick;
  always_comb begin
    per_pick.valid = urg_vld | norm_vld;
    per_pick.src   = urg_vld ? urg_idx : norm_idx;
  end

  // Critical level: cascade replaces external bit
  logic [NCRIT-1:0] crit_eff;
  always_comb begin
    crit_eff               = crit_q;
    crit_eff[CRIT_CASCADE] = urg_vld;
  end

  // Main level: cascade replaces external bit, then mask
  logic [NMAIN-1:0] main_raw, main_en;
  always_comb begin
    main_raw               = main_q;
    main_raw[MAIN_CASCADE] = norm_vld;
  end
  generate
    for (genvar n = 0; n < NMAIN; n++) begin : g_main_gate
      assign main_en[n] = main_raw[n] & ~main_mask[15-n];
    end
  endgenerate

  logic                  crit_vld, main_vld;
  logic [CRIT_SRC_W-1:0] crit_idx;
  logic [MAIN_SRC_W-1:0] main_idx;

  irqenc_pick #(.N(NCRIT), .IW(CRIT_SRC_W)) u_pick_crit (
    .req(crit_eff), .valid(crit_vld), .idx(crit_idx));
  irqenc_pick #(.N(NMAIN), .IW(MAIN_SRC_W)) u_pick_main (
    .req(main_en), .valid(main_vld), .idx(main_idx));

  // Packed status word
  always_comb begin
    enc_word = '0;
    enc_word[CRIT_VLD_BIT] = crit_vld;
    enc_word[CRIT_SRC_LSB +: CRIT_SRC_W] = crit_idx;
    enc_word[MAIN_VLD_BIT] = main_vld;
    enc_word[MAIN_SRC_LSB +: MAIN_SRC_W] = main_idx;
    enc_word[PER_VLD_BIT]  = per_pick.valid;
    enc_word[PER_SRC_LSB +: PER_SRC_W]   = per_pick.src;
  end

  assign cpu_irq_o = crit_vld | main_vld | per_pick.valid;

  irqenc_regs #(.NCRIT(NCRIT), .NMAIN(NMAIN), .NPER(NPER)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .enc_word  (enc_word),
    .crit_stat (crit_eff),
    .main_stat (main_en),
    .per_stat  (per_en),
    .per_mask  (per_mask),
    .main_mask (main_mask),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/irq_prio_enc_chk.sv
module irq_prio_enc_chk #(
  parameter int NCRIT = 4,
  parameter int NMAIN = 16,
  parameter int NPER  = 22
) (
  input logic             clk,
  input logic             rst,
  input logic [NCRIT-1:0] crit_irq_i,
  input logic [NMAIN-1:0] main_irq_i,
  input logic [NPER-1:0]  per_irq_i,
  input logic [31:0]      enc_word,
  input logic             cpu_irq_o
);
  // R1: line quiet on the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !cpu_irq_o);

  // R10: no request captured last edge means no interrupt now
  a_r10_idle_inputs: assert property (@(posedge clk) disable iff (rst)
    $past(crit_irq_i == '0 && main_irq_i == '0 && per_irq_i == '0) |-> !cpu_irq_o);

  // R3: invalid critical level reports source 0
  a_r3_crit_field_zero: assert property (@(posedge clk) disable iff (rst)
    !enc_word[10] |-> enc_word[9:8] == 2'd0);

  // R4: critical cascade marker always has a peripheral behind it
  a_r4_crit_marker: assert property (@(posedge clk) disable iff (rst)
    (enc_word[10] && enc_word[9:8] == 2'd2) |-> enc_word[29]);

  // R4: main cascade marker always has a peripheral behind it
  a_r4_main_marker: assert property (@(posedge clk) disable iff (rst)
    (enc_word[21] && enc_word[20:16] == 5'd4) |-> enc_word[29]);

  // R8: line matches the valid flags of the packed word
  a_r8_line_vs_word: assert property (@(posedge clk) disable iff (rst)
    cpu_irq_o == (enc_word[10] | enc_word[21] | enc_word[29]));
endmodule

bind irq_prio_enc irq_prio_enc_chk #(.NCRIT(NCRIT), .NMAIN(NMAIN), .NPER(NPER)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .crit_irq_i (crit_irq_i),
  .main_irq_i (main_irq_i),
  .per_irq_i  (per_irq_i),
  .enc_word   (enc_word),
  .cpu_irq_o  (cpu_irq_o)
);

// File: tb/irq_prio_enc_test.sv
module irq_prio_enc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  crit_irq_i = '0;
  logic [15:0] main_irq_i = '0;
  logic [21:0] per_irq_i  = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_enc uut (
    .clk(clk), .rst(rst), .crit_irq_i(crit_irq_i), .main_irq_i(main_irq_i),
    .per_irq_i(per_irq_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq_o(cpu_irq_o));

  typedef struct packed {
    logic [3:0]  c;
    logic [15:0] m;
    logic [21:0] p;
    logic [31:0] enc;
  } vec_t;

  // Masks all cleared; urgent peripherals are 1 and 2
  localparam vec_t VECS [12] = '{
    '{4'h0, 16'h0000, 22'h000000, 32'h0000_0000},  // R8 idle
    '{4'h0, 16'h0000, 22'h000020, 32'h2524_0000},  // R4 normal class -> main 4
    '{4'h0, 16'h0000, 22'h000004, 32'h2200_0600},  // R4 urgent -> crit 2
    '{4'h0, 16'h0000, 22'h000084, 32'h2224_0600},  // R5 urgent wins field
    '{4'h0, 16'h0208, 22'h000000, 32'h0023_0000},  // R3 lowest main
    '{4'hA, 16'h0000, 22'h000000, 32'h0000_0500},  // R3 lowest crit
    '{4'h4, 16'h0000, 22'h000000, 32'h0000_0000},  // R7 crit bit 2 ignored
    '{4'h0, 16'h0010, 22'h000000, 32'h0000_0000},  // R7 main bit 4 ignored
    '{4'h1, 16'h0001, 22'h000001, 32'h2020_0400},  // R2 all levels at once
    '{4'h0, 16'h0000, 22'h200000, 32'h3524_0000},  // R2 top peripheral
    '{4'h0, 16'h8000, 22'h000000, 32'h002F_0000},  // R2 top main
    '{4'hF, 16'hFFFF, 22'h3FFFFF, 32'h2120_0400}   // R5 everything pending
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic drive(input logic [3:0] c, input logic [15:0] m, input logic [21:0] p);
    @(negedge clk);
    crit_irq_i = c; main_irq_i = m; per_irq_i = p;
    reg_addr = 6'h24;
    @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    #1 check("R1 irq after reset", 32'(cpu_irq_o), 32'h0);
    rd(6'h00, d); check("R1 per mask reset", d, 32'h7FFF_FC00);
    rd(6'h14, d); check("R1 main mask reset", d, 32'h0001_0FFF);
    rd(6'h04, d); check("R1 priority reset", d, 32'h0);
    rd(6'h24, d); check("R1 packed word reset", d, 32'h0);

    // R6 reset masks block peripheral 5
    drive(4'h0, 16'h0000, 22'h000020);
    check("R6 masked peripheral word", reg_rdata, 32'h0);
    check("R6 masked peripheral irq", 32'(cpu_irq_o), 32'h0);

    // R6 single enable for peripheral 5; main 4 still masked
    wr(6'h00, 32'hFBFF_FFFF);
    drive(4'h0, 16'h0000, 22'h000060);
    check("R6 per bit 31-n enable", reg_rdata, 32'h2500_0000);
    check("R8 irq from peripheral only", 32'(cpu_irq_o), 32'h1);

    // R6 main reversed order
    wr(6'h14, 32'h0000_0001);
    drive(4'h0, 16'h8000, 22'h0);
    check("R6 main 15 masked by bit 0", reg_rdata, 32'h0);
    drive(4'h0, 16'h4000, 22'h0);
    check("R6 main 14 enabled", reg_rdata, 32'h002E_0000);

    // Clear masks and walk table
    wr(6'h00, 32'h0);
    wr(6'h14, 32'h0);
    for (int i = 0; i < 12; i++) begin
      drive(VECS[i].c, VECS[i].m, VECS[i].p);
      check($sformatf("R2 R3 vector %0d word", i), reg_rdata, VECS[i].enc);
      check($sformatf("R8 vector %0d irq", i), 32'(cpu_irq_o), 32'(VECS[i].enc != 0));
    end

    // R10 one-edge latency on the line
    drive(4'h0, 16'h0, 22'h0);
    @(negedge clk) main_irq_i = 16'h0100;
    #1 check("R10 not before edge", 32'(cpu_irq_o), 32'h0);
    @(posedge clk); #1 check("R10 after one edge", 32'(cpu_irq_o), 32'h1);

    // R11 status words
    drive(4'hB, 16'h0210, 22'h0);
    rd(6'h28, d); check("R11 crit status", d, 32'h0000_000B);
    rd(6'h2C, d); check("R11 R7 main status", d, 32'h0000_0200);
    drive(4'h0, 16'h0210, 22'h000020);
    rd(6'h2C, d); check("R11 main status cascade", d, 32'h0000_0210);
    rd(6'h30, d); check("R11 per status", d, 32'h0000_0020);
    drive(4'h0, 16'h0, 22'h000004);
    rd(6'h28, d); check("R11 crit status cascade", d, 32'h0000_0004);

    // R9 storage and ignored writes
    wr(6'h04, 32'hA5A5_1234);
    wr(6'h1C, 32'h0F0F_00FF);
    rd(6'h04, d); check("R9 per priority store", d, 32'hA5A5_1234);
    rd(6'h1C, d); check("R9 main priority store", d, 32'h0F0F_00FF);
    rd(6'h08, d); check("R9 untouched priority", d, 32'h0);
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h24, d); check("R9 packed word read-only", d, 32'h2200_0600);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, d); check("R9 unmapped 0x10", d, 32'h0);
    rd(6'h38, d); check("R9 unmapped 0x38", d, 32'h0);

    // R4 normal-class cascade blocked by main mask bit 11
    wr(6'h14, 32'h0000_0800);
    drive(4'h0, 16'h0, 22'h000020);
    check("R4 main 4 masked, peripheral kept", reg_rdata, 32'h2500_0000);

    // R1 reset again restores masks
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rd(6'h14, d); check("R1 main mask after second reset", d, 32'h0001_0FFF);
    rd(6'h1C, d); check("R1 priority after second reset", d, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule